// File: doc/BRIEF.md
# Two-Dimensional First-Order Recursive Image Filter

This block filters a raster-ordered image stream with a two-dimensional first-order recursion. Each output pixel is formed from three terms. The first is the current input sample. The second is one coefficient times the output directly above. The third is a second coefficient times the output directly to the left. The image is ROWS lines of COLS pixels. Samples arrive with a valid strobe, their 1-based row and column indices, and the two coefficients. A row store of COLS entries keeps the previous line's results, so the upper neighbour is always on chip.

The loop body has four elementary operations: the upper product, the left product, their sum, and the addition of the input sample. All four are evaluated for one iteration inside a single clock period, between one input register and one output register. The filter therefore accepts a new pixel on every clock, and the result of one pixel feeds the left term of the next pixel in the following cycle. A one-by-one image needs no overlap at all and simply returns its input sample.

Top module: `rfilt2d`

## Requirements
- R1: For a pixel at row r and column c, out_y equals sat(x + q(cu, y(r-1,c)) + q(cl, y(r,c-1))). All values are signed 16-bit, and cu and cl are signed Q1.14 (16384 represents 1.0). The coefficients are the ones presented with that pixel.
- R2: On row 1 the upper neighbour is taken as zero, whatever the row store holds.
- R3: On column 1 the left neighbour is taken as zero, whatever result came before it.
- R4: The product q(c, v) is the full 32-bit product plus 8192, arithmetically shifted right by 14 bits (ties go towards positive infinity), then saturated to the range -32768..32767.
- R5: The three-term sum is formed at full width and then saturated to the range -32768..32767.
- R6: out_valid is high exactly two clocks after each cycle in which in_valid is high, and at no other time. Back-to-back input gives one result per clock.
- R7: After reset, out_valid and out_last are low and out_y is 0. In any cycle without a result, out_y keeps the last result.
- R8: out_last is high together with the result for row ROWS, column COLS, and is low at all other times.
- R9: Idle cycles between pixels of a frame do not change any result.
- R10: With ROWS = COLS = 1, every pixel's result equals its input sample, and out_last is high with each result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A pixel is presented this cycle |
| in_row | input | RW | Row index, 1..ROWS |
| in_col | input | CW | Column index, 1..COLS |
| in_x | input | DW | Input sample, signed |
| coef_up | input | DW | Upper-neighbour coefficient, signed Q1.14 |
| coef_left | input | DW | Left-neighbour coefficient, signed Q1.14 |
| out_valid | output | 1 | A result is presented |
| out_y | output | DW | Filtered result, signed |
| out_last | output | 1 | Result is the final pixel of the frame |

## Verification
The bench runs several kinds of frame. Small random samples with fractional coefficients test the basic recursion and the zero borders on row 1 and column 1. Odd samples with half-valued coefficients separate round-half-up from truncation or round-to-even. Extreme samples with coefficients of -2.0 and +1.0 separate product saturation from sum saturation. Frames with random idle gaps show that spacing has no effect. Zero coefficients reduce the filter to a pass-through, and a separate one-by-one instance shows that the degenerate image returns its input unchanged.

// File: rtl/rfilt2d.sv
module rfilt2d #(
  parameter int DW   = 16,
  parameter int CF   = 14,
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int RW  = $clog2(ROWS + 1),
  localparam int CW  = $clog2(COLS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [RW-1:0]        in_row,
  input  logic [CW-1:0]        in_col,
  input  logic signed [DW-1:0] in_x,
  input  logic signed [DW-1:0] coef_up,
  input  logic signed [DW-1:0] coef_left,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_y,
  output logic                 out_last
);

  localparam int PW = 2 * DW + 1;
  localparam int AW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam logic signed [PW-1:0] RND  = PW'(1) <<< (CF - 1);
  localparam logic signed [PW-1:0] MAXV = PW'((2 ** (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -PW'(2 ** (DW - 1));

  function automatic logic signed [DW-1:0] clip(input logic signed [PW-1:0] v);
    if (v > MAXV) return MAXV[DW-1:0];
    if (v < MINV) return MINV[DW-1:0];
    return v[DW-1:0];
  endfunction

  logic                 s_v;
  logic [RW-1:0]        s_row;
  logic [CW-1:0]        s_col;
  logic signed [DW-1:0] s_x, s_cu, s_cl;
  logic signed [DW-1:0] rowbuf [COLS];

  logic [AW-1:0]        col_ix;
  logic signed [DW-1:0] up_v, left_v, b_op, c_op, y_next;
  logic signed [PW-1:0] b_full, c_full, d_sum, a_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_v   <= 1'b0;
      s_row <= '0;
      s_col <= '0;
      s_x   <= '0;
      s_cu  <= '0;
      s_cl  <= '0;
    end else begin
      s_v <= in_valid;
      if (in_valid) begin
        s_row <= in_row;
        s_col <= in_col;
        s_x   <= in_x;
        s_cu  <= coef_up;
        s_cl  <= coef_left;
      end
    end
  end

  assign col_ix = AW'(s_col - CW'(1));
  assign up_v   = (s_row == RW'(1)) ? '0 : rowbuf[col_ix];
  assign left_v = (s_col == CW'(1)) ? '0 : out_y;

  assign b_full = (PW'(s_cu) * PW'(up_v) + RND) >>> CF;
  assign c_full = (PW'(s_cl) * PW'(left_v) + RND) >>> CF;
  assign b_op   = clip(b_full);
  assign c_op   = clip(c_full);
  assign d_sum  = PW'(b_op) + PW'(c_op);
  assign a_sum  = PW'(s_x) + d_sum;
  assign y_next = clip(a_sum);

  always_ff @(posedge clk) begin
    if (s_v) rowbuf[col_ix] <= y_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_y     <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= s_v;
      out_last  <= s_v && (s_row == RW'(ROWS)) && (s_col == CW'(COLS));
      if (s_v) out_y <= y_next;
    end
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !s_v |=> $stable(out_y)); // R7
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid); // R8

endmodule

// File: tb/rfilt2d_bench.sv
module rfilt2d_bench;
  localparam int ROWS = 5;
  localparam int COLS = 6;
  localparam int RW = $clog2(ROWS + 1);
  localparam int CW = $clog2(COLS + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic                 in_valid = 1'b0;
  logic [RW-1:0]        in_row = '0;
  logic [CW-1:0]        in_col = '0;
  logic signed [15:0]   in_x = '0, coef_up = '0, coef_left = '0;
  logic                 out_valid, out_last;
  logic signed [15:0]   out_y;

  logic                 o_in_valid = 1'b0;
  logic [0:0]           o_row = 1'b1, o_col = 1'b1;
  logic signed [15:0]   o_x = '0, o_cu = '0, o_cl = '0;
  logic                 o_valid, o_last;
  logic signed [15:0]   o_y;

  rfilt2d #(.ROWS(ROWS), .COLS(COLS)) u_rfilt2d (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_row(in_row), .in_col(in_col),
    .in_x(in_x), .coef_up(coef_up), .coef_left(coef_left),
    .out_valid(out_valid), .out_y(out_y), .out_last(out_last));

  rfilt2d #(.ROWS(1), .COLS(1)) u_rfilt2d_one (
    .clk(clk), .rst(rst), .in_valid(o_in_valid), .in_row(o_row), .in_col(o_col),
    .in_x(o_x), .coef_up(o_cu), .coef_left(o_cl),
    .out_valid(o_valid), .out_y(o_y), .out_last(o_last));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int ey [4096];
  bit el [4096];
  string et [4096];
  int wp = 0, rp = 0;
  bit vprev = 1'b0;
  int hold = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int qmul(int c, int v);
    longint p;
    p = longint'(c) * longint'(v) + 64'sd8192;
    p = p >>> 14;
    return sat16(p);
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      vprev = 1'b0;
    end else if (!done) begin
      chk(out_valid == vprev, "R6 valid timing", int'(out_valid), int'(vprev));
      if (out_valid) begin
        if (rp >= wp) chk(1'b0, "R6 unexpected result", int'(out_y), 0);
        else begin
          chk(int'(out_y) == ey[rp], et[rp], int'(out_y), ey[rp]);
          chk(out_last == el[rp], "R8 last flag", int'(out_last), int'(el[rp]));
          rp++;
        end
        hold = int'(out_y);
      end else begin
        chk(int'(out_y) == hold, "R7 hold", int'(out_y), hold);
        chk(out_last == 1'b0, "R8 last idle", int'(out_last), 0);
      end
      vprev = in_valid;
    end
  end

  task automatic frame(int c1, int c2, int mode, int gap, string tag);
    int xs [ROWS][COLS];
    int ys [ROWS][COLS];
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        case (mode)
          0: xs[r][c] = int'($urandom_range(0, 4000)) - 2000;
          1: xs[r][c] = int'($urandom_range(0, 65535)) - 32768;
          2: xs[r][c] = 32767;
          3: xs[r][c] = -32768;
          default: xs[r][c] = (int'($urandom_range(0, 400)) - 200) | 1;
        endcase
      end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int up, lf;
        up = (r > 0) ? ys[r-1][c] : 0;
        lf = (c > 0) ? ys[r][c-1] : 0;
        ys[r][c] = sat16(longint'(xs[r][c]) + longint'(qmul(c1, up)) + longint'(qmul(c2, lf)));
        ey[wp] = ys[r][c];
        el[wp] = (r == ROWS - 1) && (c == COLS - 1);
        et[wp] = (r == 0) ? "R2 top row" : (c == 0) ? "R3 left column" : tag;
        wp++;
      end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        while (gap > 0 && int'($urandom_range(0, 99)) < gap) begin
          @(negedge clk); #1;
          in_valid = 1'b0;
          in_x = 16'sh1234;
        end
        @(negedge clk); #1;
        in_valid  = 1'b1;
        in_row    = RW'(r + 1);
        in_col    = CW'(c + 1);
        in_x      = 16'(xs[r][c]);
        coef_up   = 16'(c1);
        coef_left = 16'(c2);
      end
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic one_pixel(int x);
    @(negedge clk); #1;
    o_in_valid = 1'b1;
    o_x  = 16'(x);
    o_cu = 16'($urandom_range(0, 65535));
    o_cl = 16'($urandom_range(0, 65535));
    @(negedge clk); #1;
    o_in_valid = 1'b0;
    @(negedge clk);
    chk(o_valid == 1'b1, "R10 valid", int'(o_valid), 1);
    chk(int'(o_y) == x, "R10 value", int'(o_y), x);
    chk(o_last == 1'b1, "R10 last", int'(o_last), 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 reset valid", int'(out_valid), 0);
    chk(int'(out_y) == 0, "R7 reset data", int'(out_y), 0);
    chk(out_last == 1'b0, "R7 reset last", int'(out_last), 0);
    #1;
    frame(8192, 4096, 0, 0, "R1 basic");
    frame(-6000, 9000, 0, 40, "R9 gaps");
    frame(8192, 8192, 4, 0, "R4 rounding");
    frame(-8192, -8192, 4, 10, "R4 negative rounding");
    frame(-32768, -32768, 3, 0, "R4 product saturation");
    frame(16384, 16384, 2, 0, "R5 sum saturation");
    frame(0, 0, 1, 0, "R1 pass-through");
    for (int k = 0; k < 4; k++)
      frame(int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768,
            1, int'($urandom_range(0, 50)), "R1 random");
    repeat (5) @(negedge clk);
    chk(rp == wp, "R6 result count", rp, wp);
    one_pixel(-32768);
    one_pixel(32767);
    for (int k = 0; k < 4; k++) one_pixel(int'($urandom_range(0, 65535)) - 32768);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", rp, wp);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule